// File: doc/BRIEF.md
# Stretchable External Data-Memory Bus Sequencer

This block runs one read or write cycle on a multiplexed external data-memory bus each time a CPU core asks for one. The low address byte and the data share one 8-bit bus. An address-latch enable pulse marks the time when that bus carries the address. The high address byte stays on a port of its own for the whole access. Separate active-low strobes mark the read and the write.

A 3-bit stretch value, which software may rewrite at any time, sets how long each access lasts. The block takes that value when it accepts a request and keeps it until the access ends. The cost of the stretch is not linear. Value 0 gives the plain eight-clock access. Value 1 adds one clock of setup before the strobe and one clock of hold after it, and widens the strobe by two clocks. Values 2 and 3 widen only the strobe. Values 4 to 7 also widen the latch-enable pulse and add a whole four-clock machine cycle to both setup and hold. This suits slow memories and peripherals.

A single-cycle done pulse ends each access. For a read, the captured byte is on the read-data output by then.

Top module: `xmem_stretch_seq`

## Requirements
- R1: After reset, ale is 0, rd_n and wr_n are 1, ad_oe is 0 and done is 0.
- R2: A req seen while idle starts an access. ale is high for the first 2 clocks (stretch 0 to 3) or the first 6 clocks (stretch 4 to 7). During those clocks ad_oe is 1 and ad_out carries addr[7:0]. addr_hi equals addr[15:8] from the first access clock until the done pulse.
- R3: The active strobe is low for 2, 4, 8, 12, 16, 20, 24 or 28 consecutive clocks for stretch values 0 to 7.
- R4: Setup runs from the fall of ale to the start of the strobe. Hold runs from the end of the strobe to the end of the access. Each lasts 2 clocks at stretch 0, 3 clocks at stretch 1 to 3, and 7 clocks at stretch 4 to 7.
- R5: An access lasts 8, 12, 16, 20, 36, 40, 44 or 48 clocks for stretch 0 to 7. That is 8 clocks plus 4 clocks for each of 0, 1, 2, 3, 7, 8, 9 or 10 added machine cycles. done is high for exactly the single clock after the last access clock.
- R6: On a write (wr_sel = 1), only wr_n is asserted. ad_oe stays 1 and ad_out carries wdata from the fall of ale through the end of hold.
- R7: On a read (wr_sel = 0), only rd_n is asserted. ad_oe is 0 from the fall of ale to the end of the access. rdata takes ad_in on the clock edge where rd_n returns high and keeps that value afterwards.
- R8: The block samples stretch_sel on the accepting edge. A change to stretch_sel during an access does not alter that access's timing.
- R9: A req that arrives while an access is in progress is ignored. It neither changes the current access nor starts another one.
- R10: rd_n and wr_n are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stretch_sel | input | 3 | Software stretch value |
| req | input | 1 | Access request strobe |
| wr_sel | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| ad_in | input | 8 | Bus input from the memory |
| ale | output | 1 | Address-latch enable |
| ad_out | output | 8 | Multiplexed low-address/data output |
| ad_oe | output | 1 | Output enable for ad_out |
| addr_hi | output | 8 | High address byte |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| rdata | output | 8 | Captured read data |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
A wrong phase counter or a bad stretch lookup shows up as a phase edge that lands one or more clocks early or late. The first bad edge appears within the first access that uses the affected stretch value, and the bench compares every clock of every access against a computed phase schedule. A stretch value latched at the wrong moment, or a request accepted while busy, appears on the next access edge as a different length or an extra ale pulse. A capture on the wrong edge returns the complement of the byte the bench drove during the strobe.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_ALE    = 3'd1,
      PH_SETUP  = 3'd2,
      PH_STROBE = 3'd3,
      PH_HOLD   = 3'd4
   } phase_e;

   localparam int STRETCH_W = 3;

endpackage

// File: rtl/xmem_stretch_timing.sv
module xmem_stretch_timing #(
   parameter int MC_CLKS = 4,
   parameter int CNT_W   = 5
) (
   input  logic [xmem_pkg::STRETCH_W-1:0] sval,
   output logic [CNT_W-1:0]               ale_len,
   output logic [CNT_W-1:0]               setup_len,
   output logic [CNT_W-1:0]               strobe_len,
   output logic [CNT_W-1:0]               hold_len
);
   localparam int HALF_MC = MC_CLKS / 2;

   logic slow_grp;
   logic any_stretch;

   assign slow_grp    = sval[xmem_pkg::STRETCH_W-1];
   assign any_stretch = (sval != '0);

   always_comb begin
      ale_len    = CNT_W'(HALF_MC);
      setup_len  = CNT_W'(HALF_MC);
      strobe_len = CNT_W'(HALF_MC);
      if (any_stretch) begin
         setup_len  = CNT_W'(HALF_MC + 1);
         strobe_len = CNT_W'(MC_CLKS * int'(sval));
      end
      if (slow_grp) begin
         ale_len   = CNT_W'(HALF_MC + MC_CLKS);
         setup_len = CNT_W'(HALF_MC + 1 + MC_CLKS);
      end
      hold_len = setup_len;
   end

endmodule

// File: rtl/xmem_phase_ctrl.sv
module xmem_phase_ctrl #(
   parameter int MC_CLKS = 4,
   parameter int CNT_W   = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req,
   input  logic [xmem_pkg::STRETCH_W-1:0]  sval,
   output xmem_pkg::phase_e                phase,
   output logic                            last,
   output logic                            accept,
   output logic                            done,
   output logic [xmem_pkg::STRETCH_W-1:0]  stretch_q
);
   import xmem_pkg::*;

   logic [CNT_W-1:0]     cnt;
   logic [STRETCH_W-1:0] sel_val;
   logic [CNT_W-1:0]     ale_len, setup_len, strobe_len, hold_len;

   assign accept  = (phase == PH_IDLE) && req;
   assign sel_val = (phase == PH_IDLE) ? sval : stretch_q;
   assign last    = (cnt == '0);

   xmem_stretch_timing #(
      .MC_CLKS (MC_CLKS),
      .CNT_W   (CNT_W)
   ) u_timing (
      .sval       (sel_val),
      .ale_len    (ale_len),
      .setup_len  (setup_len),
      .strobe_len (strobe_len),
      .hold_len   (hold_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         done      <= 1'b0;
         stretch_q <= '0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (req) begin
                  phase     <= PH_ALE;
                  stretch_q <= sval;
                  cnt       <= ale_len - 1'b1;
               end
            end
            PH_ALE: begin
               if (last) begin
                  phase <= PH_SETUP;
                  cnt   <= setup_len - 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_SETUP: begin
               if (last) begin
                  phase <= PH_STROBE;
                  cnt   <= strobe_len - 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_STROBE: begin
               if (last) begin
                  phase <= PH_HOLD;
                  cnt   <= hold_len - 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_HOLD: begin
               if (last) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/xmem_bus_path.sv
module xmem_bus_path #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept,
   input  xmem_pkg::phase_e      phase,
   input  logic                  last,
   input  logic                  wr_sel,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [DATA_W-1:0]     ad_in,
   output logic                  ale,
   output logic [DATA_W-1:0]     ad_out,
   output logic                  ad_oe,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic                  rd_n,
   output logic                  wr_n,
   output logic [DATA_W-1:0]     rdata
);
   import xmem_pkg::*;

   localparam int HI_W = ADDR_W - DATA_W;

   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] wd_q;
   logic [HI_W-1:0]   hi_q;
   logic              wr_q;
   logic              post_ale;
   logic              strobe_on;

   assign post_ale  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
   assign strobe_on = (phase == PH_STROBE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q  <= '0;
         wd_q  <= '0;
         hi_q  <= '0;
         wr_q  <= 1'b0;
         rdata <= '0;
      end else begin
         if (accept) begin
            lo_q <= addr[DATA_W-1:0];
            hi_q <= addr[ADDR_W-1:DATA_W];
            wd_q <= wdata;
            wr_q <= wr_sel;
         end
         if (strobe_on && last && !wr_q) begin
            rdata <= ad_in;
         end
      end
   end

   assign ale     = (phase == PH_ALE);
   assign ad_oe   = ale || (post_ale && wr_q);
   assign addr_hi = hi_q;
   assign rd_n    = !(strobe_on && !wr_q);
   assign wr_n    = !(strobe_on && wr_q);

   always_comb begin
      ad_out = '0;
      if (ale) begin
         ad_out = lo_q;
      end else if (post_ale && wr_q) begin
         ad_out = wd_q;
      end
   end

endmodule

// File: rtl/xmem_stretch_seq.sv
module xmem_stretch_seq #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int MC_CLKS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [2:0]               stretch_sel,
   input  logic                     req,
   input  logic                     wr_sel,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [DATA_W-1:0]        ad_in,
   output logic                     ale,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic [DATA_W-1:0]        rdata,
   output logic                     done
);
   import xmem_pkg::*;

   localparam int CNT_W = $clog2(MC_CLKS * 8 + 1);

   if (ADDR_W <= DATA_W) begin : g_bad_addr
      $error("ADDR_W must exceed DATA_W");
   end
   if (MC_CLKS < 4 || (MC_CLKS % 2) != 0) begin : g_bad_mc
      $error("MC_CLKS must be even and at least 4");
   end

   phase_e               phase;
   logic                 last;
   logic                 accept;
   logic [STRETCH_W-1:0] stretch_q;
   logic                 busy;

   assign busy = (phase != PH_IDLE);

   xmem_phase_ctrl #(
      .MC_CLKS (MC_CLKS),
      .CNT_W   (CNT_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .sval      (stretch_sel),
      .phase     (phase),
      .last      (last),
      .accept    (accept),
      .done      (done),
      .stretch_q (stretch_q)
   );

   xmem_bus_path #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .phase   (phase),
      .last    (last),
      .wr_sel  (wr_sel),
      .addr    (addr),
      .wdata   (wdata),
      .ad_in   (ad_in),
      .ale     (ale),
      .ad_out  (ad_out),
      .ad_oe   (ad_oe),
      .addr_hi (addr_hi),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .rdata   (rdata)
   );

endmodule

// File: rtl/xmem_stretch_seq_chk.sv
module xmem_stretch_seq_chk #(
   parameter int MC_CLKS = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req,
   input logic       ale,
   input logic       ad_oe,
   input logic       rd_n,
   input logic       wr_n,
   input logic       done,
   input logic       busy,
   input logic [2:0] stretch_q
);
   logic       strb;
   logic [7:0] strb_cnt;
   logic [7:0] strb_exp;

   assign strb     = !rd_n || !wr_n;
   assign strb_exp = (stretch_q == 3'd0) ? 8'(MC_CLKS / 2) : 8'(MC_CLKS * int'(stretch_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_cnt <= '0;
      end else if (strb) begin
         strb_cnt <= strb_cnt + 1'b1;
      end else begin
         strb_cnt <= '0;
      end
   end

   // R10
   strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R2
   ale_drives_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (ad_oe && rd_n && wr_n));

   // R6
   write_strobe_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> ad_oe);

   // R7
   read_strobe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   ale_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale) |-> $past(req));

   // R8
   stretch_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(stretch_q));

   // R3
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb) |-> (strb_cnt == strb_exp));

endmodule

bind xmem_stretch_seq xmem_stretch_seq_chk #(
   .MC_CLKS (MC_CLKS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .ale       (ale),
   .ad_oe     (ad_oe),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .done      (done),
   .busy      (busy),
   .stretch_q (stretch_q)
);

// File: tb/xmem_stretch_seq_tb.sv
`timescale 1ns/1ps
module xmem_stretch_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  stretch_sel = '0;
   logic        req = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  ad_in = '0;
   logic        ale, ad_oe, rd_n, wr_n, done;
   logic [7:0]  ad_out, addr_hi, rdata;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   xmem_stretch_seq u_dut (
      .clk (clk), .rst_n (rst_n), .stretch_sel (stretch_sel), .req (req),
      .wr_sel (wr_sel), .addr (addr), .wdata (wdata), .ad_in (ad_in),
      .ale (ale), .ad_out (ad_out), .ad_oe (ad_oe), .addr_hi (addr_hi),
      .rd_n (rd_n), .wr_n (wr_n), .rdata (rdata), .done (done)
   );

   function automatic int ale_w(input int s);
      return (s >= 4) ? 6 : 2;
   endfunction
   function automatic int edge_w(input int s);
      return (s == 0) ? 2 : ((s >= 4) ? 7 : 3);
   endfunction
   function automatic int strb_w(input int s);
      return (s == 0) ? 2 : 4 * s;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // One access with stretch s; optionally change stretch_sel mid-access
   // (R8) and pulse req while busy at cycle poke (R9), 0 = no pulse.
   task automatic run_access(input int s, input bit wr, input logic [15:0] a,
                             input logic [7:0] wd, input logic [7:0] rv,
                             input bit flip_s, input int poke);
      int a_w, st_w, s_w, tot;
      a_w  = ale_w(s);
      st_w = edge_w(s);
      s_w  = strb_w(s);
      tot  = a_w + 2 * st_w + s_w;
      @(negedge clk);
      stretch_sel = 3'(s);
      req    = 1'b1;
      wr_sel = wr;
      addr   = a;
      wdata  = wd;
      ad_in  = ~rv;
      @(negedge clk);
      req = 1'b0;
      if (flip_s) stretch_sel = 3'(7 - s);
      for (int n = 1; n <= tot + 1; n++) begin
         bit in_ale, in_strb, in_busy;
         in_ale  = (n <= a_w);
         in_strb = (n > a_w + st_w) && (n <= a_w + st_w + s_w);
         in_busy = (n <= tot);
         chk(ale == in_ale, in_ale ? "R2 ale width" : "R4 ale fall", ale, in_ale);
         if (in_busy) chk(addr_hi == a[15:8], "R2 addr_hi", addr_hi, a[15:8]);
         if (in_ale) chk(ad_oe && ad_out == a[7:0], "R2 low address", ad_out, a[7:0]);
         chk(!(rd_n == 1'b0 && wr_n == 1'b0), "R10 strobe overlap", {rd_n, wr_n}, 2'b11);
         chk(wr_n == !(in_strb && wr), in_strb ? "R3 wr strobe" : "R4 wr setup/hold", wr_n, !(in_strb && wr));
         chk(rd_n == !(in_strb && !wr), in_strb ? "R3 rd strobe" : "R4 rd setup/hold", rd_n, !(in_strb && !wr));
         chk(done == (n == tot + 1), (flip_s || poke != 0) ? "R8/R9 done timing" : "R5 done", done, n == tot + 1);
         if (!in_ale && in_busy) begin
            if (wr) chk(ad_oe && ad_out == wd, "R6 write data", {ad_oe, ad_out}, {1'b1, wd});
            else    chk(!ad_oe, "R7 bus released", ad_oe, 0);
         end
         ad_in = in_strb ? rv : ~rv;
         req   = (poke != 0 && n == poke);
         @(negedge clk);
      end
      req = 1'b0;
      if (!wr) chk(rdata == rv, "R7 rdata capture", rdata, rv);
      if (poke != 0) begin
         for (int k = 0; k < 3; k++) begin
            chk(!ale && !done, "R9 no extra access", {ale, done}, 0);
            @(negedge clk);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      $display("FAIL watchdog expired actual=running expected=finished");
      n_chk++;
      n_bad++;
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ale == 1'b0, "R1 ale", ale, 0);
      chk(rd_n && wr_n, "R1 strobes", {rd_n, wr_n}, 2'b11);
      chk(ad_oe == 1'b0, "R1 ad_oe", ad_oe, 0);
      chk(done == 1'b0, "R1 done", done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(ale == 1'b0 && rd_n && wr_n && !ad_oe, "R1 idle after reset", {ale, rd_n, wr_n, ad_oe}, 4'b0110);

      for (int s = 0; s < 8; s++) begin
         run_access(s, 1'b1, 16'hA55A ^ 16'(s), 8'h3C + 8'(s), 8'h00, 1'b0, 0);
         run_access(s, 1'b0, 16'h1234 + 16'(s * 257), 8'h00, 8'hC3 ^ 8'(s), 1'b0, 0);
      end
      // R8 mid-access stretch change
      run_access(0, 1'b0, 16'hBEEF, 8'h00, 8'h5A, 1'b1, 0);
      run_access(7, 1'b1, 16'h0F0F, 8'h81, 8'h00, 1'b1, 0);
      run_access(1, 1'b0, 16'h7001, 8'h00, 8'hE7, 1'b1, 0);
      // R9 requests while busy
      run_access(0, 1'b1, 16'h4242, 8'h99, 8'h00, 1'b0, 3);
      run_access(5, 1'b0, 16'hFFFF, 8'h00, 8'h01, 1'b0, 20);
      // back-to-back with random stimulus
      for (int i = 0; i < 40; i++) begin
         int s, pk;
         bit w, fl;
         s  = int'($urandom_range(0, 7));
         w  = 1'($urandom_range(0, 1));
         fl = 1'($urandom_range(0, 1));
         pk = ($urandom_range(0, 3) == 0) ? 2 : 0;
         run_access(s, w, 16'($urandom()), 8'($urandom()), 8'($urandom()), fl, pk);
      end
      finish_run();
   end

endmodule